// File: doc/BRIEF.md
# Set/Clear GPIO Port with Implicit Direction

This block is a 32-pin general-purpose I/O port on a simple 32-bit register bus. Every pin has one output-data bit and one output-enable bit. Software changes them only through write-one-to-act registers. One register drives the selected pins high and another drives them low. Either of these writes also turns on the output driver of each selected pin, so no separate direction write is needed. A third register turns off the driver of the selected pins so that they act as inputs. Bits written as 0 leave their pins untouched in every case.

Pin levels pass through a two-flop synchronizer. After reset the input path is gated off. While it is gated, the level register reads as 0 and all interrupt requests stay low. The gate opens after the first write to the input-arm register, whatever data that write carries, and stays open until the next reset. Each pin has its own level interrupt request, taken from its synchronized and gated input and held in a register.

Reads are registered: the read data appears one cycle after the read strobe and holds until the next read. Reading the level register returns the gated pin levels. Reading any other address returns the current output-data vector.

Top module: `gpio_setclr_port`

## Requirements
- R1: While `rst` is high, and right after it, `pin_out`, `pin_oe`, `pin_irq` and `bus_rdata` are all 0 and the input gate is closed.
- R2: A write to word address 0 (drive-high) sets `pin_out[n]` and `pin_oe[n]` for every bit n written as 1, at the clock edge of the write. Bits written as 0 leave both unchanged.
- R3: A write to word address 1 (drive-low) clears `pin_out[n]` and sets `pin_oe[n]` for every bit n written as 1. Bits written as 0 leave both unchanged.
- R4: A write to word address 2 (release) clears `pin_oe[n]` for every bit n written as 1. It never changes `pin_out`.
- R5: A read of word address 3 (levels) returns the gated synchronized pin vector on `bus_rdata` one cycle after the strobe. A change of `pin_in` set up before edge e1 is not seen by reads at edges e1 and e2, and is seen by a read at edge e3.
- R6: While the input gate is closed, a level read returns 0 and `pin_irq` stays 0, whatever `pin_in` is.
- R7: Any write to word address 4 (input-arm), including one with data 0, opens the input gate. Only reset closes it again.
- R8: `pin_irq[n]` follows pin n one to one. A change of `pin_in` set up before edge e1 reaches `pin_irq` at edge e3 once the gate is open.
- R9: A read of word address 0, 1, 2, 4, 5, 6 or 7 returns the current `pin_out` vector.
- R10: A write to word address 3, 5, 6 or 7 changes neither `pin_out` nor `pin_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data, one bit per pin |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Asynchronous pin levels from the pads |
| pin_out | output | 32 | Output data to the pads |
| pin_oe | output | 32 | Output-driver enable to the pads |
| pin_irq | output | 32 | Per-pin level interrupt requests |

## Verification
A wrong output-data or output-enable bit shows up on `pin_out` or `pin_oe` at the edge that follows the faulty write. It also shows up in the next readback of a write-only address one cycle later. A synchronizer that is one stage short or one stage long moves the first level read and the first interrupt that see a new input by exactly one edge, so the bench checks the reads at e2 and e3 both ways. If the input gate opens too early or is not cleared by reset, interrupts or nonzero level reads appear before the arm write. If it never opens, the interrupts stay silent one edge after that write.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    REG_DRIVE_HI = 3'd0,
    REG_DRIVE_LO = 3'd1,
    REG_RELEASE  = 3'd2,
    REG_LEVELS   = 3'd3,
    REG_IN_ARM   = 3'd4
  } reg_sel_e;

  typedef struct packed {
    logic drive_hi;
    logic drive_lo;
    logic rel;
    logic arm;
    logic rd_any;
    logic rd_levels;
  } bus_cmd_t;
endpackage

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
  import gpio_port_pkg::*;
(
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [REG_AW-1:0] bus_addr,
  output bus_cmd_t          cmd
);
  logic wr_en;
  logic rd_en;

  assign wr_en = bus_sel & bus_wr;
  assign rd_en = bus_sel & ~bus_wr;

  always_comb begin
    cmd           = '0;
    cmd.drive_hi  = wr_en && (bus_addr == REG_DRIVE_HI);
    cmd.drive_lo  = wr_en && (bus_addr == REG_DRIVE_LO);
    cmd.rel       = wr_en && (bus_addr == REG_RELEASE);
    cmd.arm       = wr_en && (bus_addr == REG_IN_ARM);
    cmd.rd_any    = rd_en;
    cmd.rd_levels = rd_en && (bus_addr == REG_LEVELS);
  end
endmodule

// File: rtl/gpio_pin_state.sv
module gpio_pin_state #(
  parameter int PIN_CNT = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               drive_hi,
  input  logic               drive_lo,
  input  logic               rel,
  input  logic [PIN_CNT-1:0] wmask,
  output logic [PIN_CNT-1:0] out_q,
  output logic [PIN_CNT-1:0] oe_q
);
  for (genvar i = 0; i < PIN_CNT; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) begin
        out_q[i] <= 1'b0;
        oe_q[i]  <= 1'b0;
      end else if (wmask[i]) begin
        if (drive_hi) begin
          out_q[i] <= 1'b1;
          oe_q[i]  <= 1'b1;
        end else if (drive_lo) begin
          out_q[i] <= 1'b0;
          oe_q[i]  <= 1'b1;
        end else if (rel) begin
          oe_q[i]  <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/gpio_input_path.sv
module gpio_input_path #(
  parameter int PIN_CNT     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               arm,
  input  logic [PIN_CNT-1:0] pin_in,
  output logic [PIN_CNT-1:0] level,
  output logic [PIN_CNT-1:0] irq_q
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0][PIN_CNT-1:0] sync_q;
  logic                                armed_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q[0] <= '0;
    else     sync_q[0] <= pin_in;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) sync_q[s] <= '0;
      else     sync_q[s] <= sync_q[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      armed_q <= 1'b0;
    else if (arm) armed_q <= 1'b1;
  end

  assign level = sync_q[LAST] & {PIN_CNT{armed_q}};

  always_ff @(posedge clk) begin
    if (rst) irq_q <= '0;
    else     irq_q <= level;
  end
endmodule

// File: rtl/gpio_setclr_port.sv
module gpio_setclr_port
  import gpio_port_pkg::*;
#(
  parameter int PIN_CNT     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [REG_AW-1:0]  bus_addr,
  input  logic [PIN_CNT-1:0] bus_wdata,
  output logic [PIN_CNT-1:0] bus_rdata,
  input  logic [PIN_CNT-1:0] pin_in,
  output logic [PIN_CNT-1:0] pin_out,
  output logic [PIN_CNT-1:0] pin_oe,
  output logic [PIN_CNT-1:0] pin_irq
);
  bus_cmd_t           cmd;
  logic [PIN_CNT-1:0] level;

  gpio_bus_decode i_decode (
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .cmd      (cmd)
  );

  gpio_pin_state #(.PIN_CNT(PIN_CNT)) i_state (
    .clk      (clk),
    .rst      (rst),
    .drive_hi (cmd.drive_hi),
    .drive_lo (cmd.drive_lo),
    .rel      (cmd.rel),
    .wmask    (bus_wdata),
    .out_q    (pin_out),
    .oe_q     (pin_oe)
  );

  gpio_input_path #(.PIN_CNT(PIN_CNT), .SYNC_STAGES(SYNC_STAGES)) i_inpath (
    .clk    (clk),
    .rst    (rst),
    .arm    (cmd.arm),
    .pin_in (pin_in),
    .level  (level),
    .irq_q  (pin_irq)
  );

  always_ff @(posedge clk) begin
    if (rst)             bus_rdata <= '0;
    else if (cmd.rd_any) bus_rdata <= cmd.rd_levels ? level : pin_out;
  end
endmodule

// File: rtl/gpio_setclr_port_chk.sv
module gpio_setclr_port_chk
  import gpio_port_pkg::*;
#(
  parameter int PIN_CNT = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_sel,
  input logic               bus_wr,
  input logic [REG_AW-1:0]  bus_addr,
  input logic [PIN_CNT-1:0] bus_wdata,
  input logic [PIN_CNT-1:0] bus_rdata,
  input logic [PIN_CNT-1:0] pin_out,
  input logic [PIN_CNT-1:0] pin_oe,
  input logic [PIN_CNT-1:0] pin_irq
);
  logic seen_arm_q;
  logic wr_hi, wr_lo, wr_rel, wr_dead, rd_out;

  assign wr_hi   = bus_sel && bus_wr && (bus_addr == REG_DRIVE_HI);
  assign wr_lo   = bus_sel && bus_wr && (bus_addr == REG_DRIVE_LO);
  assign wr_rel  = bus_sel && bus_wr && (bus_addr == REG_RELEASE);
  assign wr_dead = bus_sel && bus_wr && (bus_addr == REG_LEVELS || bus_addr > REG_IN_ARM);
  assign rd_out  = bus_sel && !bus_wr && (bus_addr != REG_LEVELS);

  always_ff @(posedge clk) begin
    if (rst) seen_arm_q <= 1'b0;
    else if (bus_sel && bus_wr && bus_addr == REG_IN_ARM) seen_arm_q <= 1'b1;
  end

  // R2
  drive_hi_chk: assert property (@(posedge clk) disable iff (rst)
    wr_hi |=> ((pin_out & $past(bus_wdata)) == $past(bus_wdata)) &&
              ((pin_oe & $past(bus_wdata)) == $past(bus_wdata)));

  // R3
  drive_lo_chk: assert property (@(posedge clk) disable iff (rst)
    wr_lo |=> ((pin_out & $past(bus_wdata)) == '0) &&
              ((pin_oe & $past(bus_wdata)) == $past(bus_wdata)));

  // R4
  release_chk: assert property (@(posedge clk) disable iff (rst)
    wr_rel |=> ((pin_oe & $past(bus_wdata)) == '0) && (pin_out == $past(pin_out)));

  // R10
  dead_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_dead |=> $stable(pin_out) && $stable(pin_oe));

  // R9
  readback_chk: assert property (@(posedge clk) disable iff (rst)
    rd_out |=> (bus_rdata == $past(pin_out)));

  // R6
  gated_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (pin_irq != '0) |-> seen_arm_q);
endmodule

bind gpio_setclr_port gpio_setclr_port_chk #(.PIN_CNT(PIN_CNT)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .pin_irq   (pin_irq)
);

// File: tb/test_gpio_setclr_port.sv
`timescale 1ns/1ps
module test_gpio_setclr_port;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_sel;
  logic        bus_wr;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in;
  logic [31:0] pin_out;
  logic [31:0] pin_oe;
  logic [31:0] pin_irq;

  int checks   = 0;
  int failures = 0;
  logic [31:0] exp_out = '0;
  logic [31:0] exp_oe  = '0;
  logic [31:0] rd;

  always #2.5 clk = ~clk;

  gpio_setclr_port i_gpio_setclr_port (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_irq(pin_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // All bus tasks start and end at a falling edge.
  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic chk_pins(input string req);
    chk({req, " pin_out"}, pin_out, exp_out);
    chk({req, " pin_oe"},  pin_oe,  exp_oe);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 rst pin_out", pin_out, '0);
    chk("R1 rst pin_oe", pin_oe, '0);
    chk("R1 rst pin_irq", pin_irq, '0);
    chk("R1 rst bus_rdata", bus_rdata, '0);
    rst = 1'b0;
    exp_out = '0; exp_oe = '0;
    @(negedge clk);
  endtask

  task automatic t_drive_hi();
    bus_write(3'd0, 32'h0000_00FF);
    exp_out |= 32'h0000_00FF; exp_oe |= 32'h0000_00FF;
    chk_pins("R2 set");
    bus_write(3'd0, 32'h0);
    chk_pins("R2 zero mask");
  endtask

  task automatic t_drive_lo();
    bus_write(3'd1, 32'h0000_000F);
    exp_out &= ~32'h0000_000F; exp_oe |= 32'h0000_000F;
    chk_pins("R3 clear driven");
    bus_write(3'd1, 32'hF000_0000);
    exp_out &= ~32'hF000_0000; exp_oe |= 32'hF000_0000;
    chk_pins("R3 clear turns on driver");
  endtask

  task automatic t_release();
    bus_write(3'd2, 32'h8000_0013);
    exp_oe &= ~32'h8000_0013;
    chk_pins("R4 release");
  endtask

  task automatic t_dead_writes();
    bus_write(3'd3, 32'hFFFF_FFFF);
    bus_write(3'd5, 32'hFFFF_FFFF);
    bus_write(3'd6, 32'hFFFF_FFFF);
    bus_write(3'd7, 32'hFFFF_FFFF);
    chk_pins("R10 ignored writes");
  endtask

  task automatic t_readback();
    foreach (exp_oe[k]) if (k < 8 && k != 3) begin
      bus_read(3'(k), rd);
      chk("R9 readback", rd, exp_out);
    end
  endtask

  task automatic t_gated(input string req);
    pin_in = 32'hA5A5_5A5A;
    repeat (4) @(negedge clk);
    bus_read(3'd3, rd);
    chk({req, " R6 gated level"}, rd, '0);
    chk({req, " R6 gated irq"}, pin_irq, '0);
  endtask

  task automatic t_arm();
    bus_write(3'd4, 32'h0);
    @(negedge clk);
    chk("R7 R8 irq after arm", pin_irq, 32'hA5A5_5A5A);
    bus_read(3'd3, rd);
    chk("R5 level after arm", rd, 32'hA5A5_5A5A);
  endtask

  task automatic t_timing();
    pin_in = 32'h1234_5678;
    bus_read(3'd3, rd);
    chk("R5 read at e1", rd, 32'hA5A5_5A5A);
    chk("R8 irq after e1", pin_irq, 32'hA5A5_5A5A);
    bus_read(3'd3, rd);
    chk("R5 read at e2", rd, 32'hA5A5_5A5A);
    chk("R8 irq after e2", pin_irq, 32'hA5A5_5A5A);
    bus_read(3'd3, rd);
    chk("R5 read at e3", rd, 32'h1234_5678);
    chk("R8 irq after e3", pin_irq, 32'h1234_5678);
    bus_write(3'd4, 32'hFFFF_FFFF);
    pin_in = 32'h0000_0001;
    repeat (4) @(negedge clk);
    chk("R7 R8 stays armed", pin_irq, 32'h0000_0001);
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0;
    bus_wdata = '0; pin_in = '0;
    @(negedge clk);
    do_reset();
    t_drive_hi();
    t_drive_lo();
    t_release();
    t_dead_writes();
    t_readback();
    t_gated("first");
    t_arm();
    t_timing();
    pin_in = 32'hA5A5_5A5A;
    do_reset();
    t_gated("after reset");
    t_arm();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule